// File: doc/BRIEF.md
# Black-Level Averaging Error Generator

This block sits between a pixel ADC and the offset-correction loop of an image sensor front end. A window strobe marks the optical-black pixels at the start of a line. While the strobe is high, each sample is limited to a ceiling of 127 so that a defective bright pixel cannot drag the estimate upward. The limited samples are then summed. When sixteen pixels have been collected, or when the strobe drops before that, the average is taken and a programmable 6-bit target code is subtracted from it. The result is a signed error with a one-cycle valid pulse. A positive error means the black level sits too high and has to be lowered. A negative error means it has to be raised.

The ADC samples also go to a pixel output port one cycle later, unchanged. Limiting applies only to the calibration path. The target code resets to 32 and can be rewritten at any time through a write strobe.

Top module: `ob_level_err`

## Requirements
- R1: `pix_out` equals the `adc_in` value of the previous cycle, unlimited, for every value 0..1023, whether the strobe is high or low.
- R2: Inside a window, a sample above 127 enters the average as 127. Samples at or below 127 enter unchanged.
- R3: Only samples taken while `cal_win` is high contribute. A low-to-high change of `cal_win` starts a new window, and samples from earlier windows have no effect on it.
- R4: When the 16th sample of a window is taken, `err_vld` is high in the following cycle and `err_out` = floor(sum of the 16 limited samples / 16) − target. Later samples in the same window are ignored, and the strobe falling afterwards produces no second pulse.
- R5: If `cal_win` is sampled low after n samples with 1 ≤ n ≤ 15, `err_vld` is high in the following cycle. In that case `err_out` = floor(sum of the first p samples / p) − target, where p is the largest power of two not above n.
- R6: After reset the target is 32, `err_vld` is 0 and `pix_out` is 0.
- R7: When `tgt_we` is high at a clock edge, `tgt_wdata` becomes the target for results produced at later edges. A result produced at that same edge still uses the previous target.
- R8: `err_out` is an 8-bit two's-complement value in the range −63..127. Positive means the black level is above the target.
- R9: `err_vld` is never high on two consecutive cycles. `err_out` keeps its last value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_in | input | 10 | Raw pixel sample |
| cal_win | input | 1 | High on optical-black pixels |
| tgt_we | input | 1 | Target write strobe |
| tgt_wdata | input | 6 | New target code |
| pix_out | output | 10 | Registered, unmodified pixel sample |
| err_out | output | 8 | Signed average-minus-target error |
| err_vld | output | 1 | One-cycle pulse marking a new error |

## Verification
Two events can land on the same clock edge: the sample that completes a window, and a target write. The bench forces this by raising `tgt_we` in the cycle that carries the 16th sample. The result must still be computed against the old target, and the next window must use the new one. A second collision comes from dropping the strobe right after a full window. The bench checks that the drop neither produces a second pulse nor clears the result. Random windows of lengths 1 to 20, with half the samples above the ceiling, are compared against a bench model that averages stored sample lists.

// File: rtl/ob_level_err.sv
module ob_level_err #(
  parameter int DW      = 10,
  parameter int CLIP    = 127,
  parameter int LOGN    = 4,
  parameter int TW      = 6,
  parameter int EW      = 8,
  parameter int TGT_RST = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        adc_in,
  input  logic                 cal_win,
  input  logic                 tgt_we,
  input  logic [TW-1:0]        tgt_wdata,
  output logic [DW-1:0]        pix_out,
  output logic signed [EW-1:0] err_out,
  output logic                 err_vld
);
  localparam int NPIX = 1 << LOGN;
  localparam int AW   = $clog2(CLIP + 1) + LOGN;
  localparam int CW   = LOGN + 1;
  localparam int KW   = $clog2(LOGN);

  logic          win_d;
  logic [CW-1:0] cnt;
  logic [AW-1:0] acc, psum;
  logic [KW-1:0] pk;
  logic [TW-1:0] tgt;

  function automatic logic [KW-1:0] flog(input logic [CW-1:0] v);
    flog = '0;
    for (int i = 0; i < CW - 1; i++)
      if (v[i]) flog = KW'(i);
  endfunction

  wire [DW-1:0] clip   = (adc_in > DW'(CLIP)) ? DW'(CLIP) : adc_in;
  wire          rise   = cal_win & ~win_d;
  wire          take   = cal_win & (rise | (cnt < CW'(NPIX)));
  wire [CW-1:0] cnt_nx = rise ? CW'(1) : cnt + CW'(1);
  wire [AW-1:0] acc_nx = (rise ? '0 : acc) + AW'(clip);
  wire          full   = take & (cnt_nx == CW'(NPIX));
  wire          early  = win_d & ~cal_win & (cnt != '0) & (cnt < CW'(NPIX));
  wire          pow2   = ((cnt_nx & (cnt_nx - CW'(1))) == '0) && (cnt_nx < CW'(NPIX));
  wire [AW-1:0] avg    = full ? (acc_nx >> LOGN) : (psum >> pk);
  wire signed [EW-1:0] err = $signed(EW'(avg)) - $signed(EW'(tgt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_d   <= 1'b0;
      cnt     <= '0;
      acc     <= '0;
      psum    <= '0;
      pk      <= '0;
      tgt     <= TW'(TGT_RST);
      pix_out <= '0;
      err_out <= '0;
      err_vld <= 1'b0;
    end else begin
      win_d   <= cal_win;
      pix_out <= adc_in;
      err_vld <= full | early;
      if (full | early) err_out <= err;
      if (take) begin
        acc <= acc_nx;
        cnt <= cnt_nx;
        if (pow2) begin
          psum <= acc_nx;
          pk   <= flog(cnt_nx);
        end
      end
      if (tgt_we) tgt <= tgt_wdata;
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |=> !err_vld);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld |-> $stable(err_out) || $past(!rst_n));
  a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> ($signed(err_out) >= -$signed(EW'((1 << TW) - 1))));
  a_r3_rise_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_win) |=> !err_vld);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(NPIX));
endmodule

// File: tb/ob_level_err_tb.sv
`timescale 1ns/1ps
module ob_level_err_tb;
  logic clk = 0, rst_n = 0;
  logic [9:0] adc_in = 0;
  logic cal_win = 0, tgt_we = 0;
  logic [5:0] tgt_wdata = 0;
  logic [9:0] pix_out;
  logic signed [7:0] err_out;
  logic err_vld;

  int checks = 0, errors = 0;
  int smp[16];
  int n = 0, tgt_m = 32, last_err = 0;
  bit prev_win = 0;

  ob_level_err u_dut (.clk(clk), .rst_n(rst_n), .adc_in(adc_in), .cal_win(cal_win),
    .tgt_we(tgt_we), .tgt_wdata(tgt_wdata), .pix_out(pix_out), .err_out(err_out),
    .err_vld(err_vld));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lim(input int v);
    return (v > 127) ? 127 : v;
  endfunction

  function automatic int avg_first(input int cnt);
    int p = 1, s = 0;
    while (p * 2 <= cnt) p = p * 2;
    for (int i = 0; i < p; i++) s += smp[i];
    return s / p;
  endfunction

  task automatic step(input int a, input bit w, input bit we = 0, input int wd = 0);
    bit ev = 0;
    int ee = 0;
    adc_in = 10'(a); cal_win = w; tgt_we = we; tgt_wdata = 6'(wd);
    if (w) begin
      if (!prev_win) n = 0;
      if (n < 16) begin
        smp[n] = lim(a); n++;
        if (n == 16) begin ev = 1; ee = avg_first(16) - tgt_m; end
      end
    end else if (prev_win && n > 0 && n < 16) begin
      ev = 1; ee = avg_first(n) - tgt_m;
    end
    prev_win = w;
    @(posedge clk);
    @(negedge clk);
    if (we) tgt_m = wd;
    chk(pix_out == 10'(a), "R1 pix_out", int'(pix_out), a);
    chk(err_vld == ev, "R9/R4/R5 err_vld", int'(err_vld), int'(ev));
    if (ev) begin
      last_err = ee;
      chk(int'(err_out) == ee, "R4/R5/R2/R8 err_out", int'(err_out), ee);
    end else
      chk(int'(err_out) == last_err, "R9 err_out hold", int'(err_out), last_err);
    tgt_we = 0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    chk(err_vld == 0, "R6 reset err_vld", int'(err_vld), 0);
    chk(pix_out == 0, "R6 reset pix_out", int'(pix_out), 0);
    rst_n = 1;
    // R6: zero black level against reset target gives -32
    for (int i = 0; i < 16; i++) step(0, 1);
    step(5, 0);
    // R2: all saturated samples give 127-32; R1 sees 1023 unclipped
    for (int i = 0; i < 16; i++) step(1023, 1);
    // R4: extra samples ignored, fall makes no second pulse
    for (int i = 0; i < 3; i++) step(0, 1);
    step(0, 0);
    // R5: single-pixel and three-pixel early windows
    step(100, 1); step(0, 0);
    step(10, 1); step(20, 1); step(900, 1); step(0, 0);
    // R7: write on the 16th-sample edge keeps old target for that result
    for (int i = 0; i < 15; i++) step(64, 1);
    step(64, 1, 1, 0);
    step(0, 0);
    for (int i = 0; i < 16; i++) step(64, 1);
    step(0, 0);
    // R8: extremes (0 - 63) and (127 - 0)
    step(0, 0, 1, 63);
    for (int i = 0; i < 16; i++) step(0, 1);
    step(0, 0, 1, 0);
    for (int i = 0; i < 16; i++) step(500, 1);
    step(0, 0);
    // R3: strobe low samples never contribute; random windows
    for (int w = 0; w < 300; w++) begin
      int len = 1 + int'($urandom_range(19));
      int gap = 1 + int'($urandom_range(4));
      for (int i = 0; i < len; i++) begin
        int a = ($urandom_range(1) == 1) ? int'($urandom_range(1023)) : int'($urandom_range(127));
        bit we = ($urandom_range(15) == 0);
        step(a, 1, we, int'($urandom_range(63)));
      end
      for (int i = 0; i < gap; i++) step(int'($urandom_range(1023)), 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule